// File: doc/BRIEF.md
# Q15 Fractional Multiply-Accumulate Unit

This block multiplies two Q15 fractions and either accumulates the Q31 product into one of a small bank of 64-bit accumulators or returns it directly as a 32-bit result. The two Q15 operands are both taken from the upper halfwords of the two 32-bit sources, or both from the lower halfwords. A per-operation select input chooses which.

Every product is clamped to the Q31 range. One accumulate mode lets the 64-bit sum wrap. The other clamps the sum to Q31 and stores it sign-extended. Move operations give register-style access to either half of any accumulator. A shift-in move pushes the low half into the high half and loads a new low word. Accumulator 0 doubles as the hi/lo pair that the direct multiply overwrites. A sticky flag records any saturation event.

A caller drives the operation fields and pulses `start` for one cycle. On the next clock the unit raises `done` for one cycle, the accumulators are updated, and `result` is valid.

Top module: `q15_mac_unit`

## Requirements
- R1: After reset, `result` is 0, `done` is 0, `sat_flag` is 0, and every accumulator reads 0 in both halves.
- R2: With `hsel`=1 the operands are `src_a[31:16]` and `src_b[31:16]`. With `hsel`=0 they are `src_a[15:0]` and `src_b[15:0]`. Both are signed Q15 values.
- R3: Op 2 (MUL) sets `result` to the Q31 product (a*b)<<1. It also writes that product, sign-extended to 64 bits, into accumulator 0.
- R4: The operand pair 0x8000 × 0x8000 gives the product 0x7FFFFFFF and sets `sat_flag`.
- R5: Op 0 (MAC) adds the sign-extended product to the selected accumulator, wrapping modulo 2^64.
- R6: Op 1 (MACS) adds the same way. A sum above 0x7FFFFFFF is stored as 0x000000007FFFFFFF, and a sum below -2^31 is stored as 0xFFFFFFFF80000000. Either clamp sets `sat_flag`.
- R7: Op 3 (RDHI) sets `result` to bits 63:32 of the selected accumulator. Op 4 (RDLO) sets it to bits 31:0.
- R8: Op 5 (WRHI) writes `src_a` into bits 63:32 of the selected accumulator, and op 6 (WRLO) writes it into bits 31:0. In each case the other half is left unchanged.
- R9: Op 7 (SHIN) moves the selected accumulator's low half into its high half and writes `src_a` into its low half.
- R10: `done` is high exactly in the cycle after a `start` pulse. `result` changes only in that cycle and only for ops 2, 3 and 4.
- R11: `sat_flag` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation strobe, one cycle |
| op | input | 3 | Operation code |
| acc_sel | input | 2 | Accumulator index |
| hsel | input | 1 | Halfword select: 1 upper, 0 lower |
| src_a | input | 32 | First source / write data |
| src_b | input | 32 | Second source |
| result | output | 32 | Register result |
| done | output | 1 | Completion pulse |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The accumulators are visible only through the read ops. A wrong accumulator value therefore shows up at the first RDHI or RDLO of that index. The bench places such a read right after every accumulate, write and shift-in, so a fault appears within two operations. A missing clamp or wrap shows as a wrong high word on the next read. A wrong halfword select or product shift shows in the very next MUL result, one cycle after `start`.

// File: rtl/q15_mac_unit.sv
module q15_mac_unit #(
  parameter int NACC = 4,
  localparam int AW = $clog2(NACC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [AW-1:0] acc_sel,
  input  logic          hsel,
  input  logic [31:0]   src_a,
  input  logic [31:0]   src_b,
  output logic [31:0]   result,
  output logic          done,
  output logic          sat_flag
);
  localparam logic [2:0] OP_MAC = 3'd0, OP_MACS = 3'd1, OP_MUL = 3'd2, OP_RDHI = 3'd3,
                         OP_RDLO = 3'd4, OP_WRHI = 3'd5, OP_WRLO = 3'd6, OP_SHIN = 3'd7;

  logic [63:0] acc [NACC];

  logic signed [15:0] ha, hb;
  logic signed [31:0] mult;
  logic [31:0] prod;
  logic        prod_ovf, sum_hi, sum_lo;
  logic [63:0] prod64, cur, sum, sat_sum;

  assign ha       = hsel ? src_a[31:16] : src_a[15:0];
  assign hb       = hsel ? src_b[31:16] : src_b[15:0];
  assign mult     = ha * hb;
  assign prod_ovf = (ha == 16'sh8000) && (hb == 16'sh8000);
  assign prod     = prod_ovf ? 32'h7FFF_FFFF : {mult[30:0], 1'b0};
  assign prod64   = {{32{prod[31]}}, prod};
  assign cur      = acc[acc_sel];
  assign sum      = cur + prod64;
  assign sum_hi   = !sum[63] && (sum[63:31] != 33'h0);
  assign sum_lo   =  sum[63] && (sum[63:31] != {33{1'b1}});
  assign sat_sum  = sum_hi ? 64'h0000_0000_7FFF_FFFF :
                    sum_lo ? 64'hFFFF_FFFF_8000_0000 : sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NACC; i++) acc[i] <= '0;
      result   <= '0;
      done     <= 1'b0;
      sat_flag <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        case (op)
          OP_MAC: begin
            acc[acc_sel] <= sum;
            if (prod_ovf) sat_flag <= 1'b1;
          end
          OP_MACS: begin
            acc[acc_sel] <= sat_sum;
            if (prod_ovf || sum_hi || sum_lo) sat_flag <= 1'b1;
          end
          OP_MUL: begin
            result <= prod;
            acc[0] <= prod64;
            if (prod_ovf) sat_flag <= 1'b1;
          end
          OP_RDHI: result <= cur[63:32];
          OP_RDLO: result <= cur[31:0];
          OP_WRHI: acc[acc_sel][63:32] <= src_a;
          OP_WRLO: acc[acc_sel][31:0]  <= src_a;
          OP_SHIN: acc[acc_sel] <= {cur[31:0], src_a};
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/q15_mac_unit_chk.sv
module q15_mac_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [2:0]  op,
  input logic        hsel,
  input logic [31:0] src_a,
  input logic [31:0] src_b,
  input logic [31:0] result,
  input logic        done,
  input logic        sat_flag
);
  logic [15:0] ca, cb;
  assign ca = hsel ? src_a[31:16] : src_a[15:0];
  assign cb = hsel ? src_b[31:16] : src_b[15:0];

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) start |=> done); // R10
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(start)); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !start |=> $stable(result)); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) sat_flag |=> sat_flag); // R11
  AST_MIN_SQUARE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 3'd2 && ca == 16'h8000 && cb == 16'h8000) |=> (result == 32'h7FFF_FFFF && sat_flag)); // R4
endmodule

bind q15_mac_unit q15_mac_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .hsel(hsel),
  .src_a(src_a), .src_b(src_b), .result(result), .done(done), .sat_flag(sat_flag)
);

// File: tb/q15_mac_unit_bench.sv
module q15_mac_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, hsel = 1'b0;
  logic [2:0] op = '0;
  logic [1:0] acc_sel = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [31:0] result;
  logic done, sat_flag;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  q15_mac_unit u_q15_mac_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .acc_sel(acc_sel), .hsel(hsel),
    .src_a(src_a), .src_b(src_b), .result(result), .done(done), .sat_flag(sat_flag)
  );

  // {chk, req, op, sel, hsel, a, b, expected}
  localparam int NV = 27;
  localparam logic [106:0] VEC [NV] = '{
    {1'b0, 4'd8,  3'd5, 2'd1, 1'b0, 32'h12345678, 32'h0, 32'h0},          // R8
    {1'b0, 4'd8,  3'd6, 2'd1, 1'b0, 32'h9ABCDEF0, 32'h0, 32'h0},          // R8
    {1'b1, 4'd7,  3'd3, 2'd1, 1'b0, 32'h0, 32'h0, 32'h12345678},          // R7
    {1'b1, 4'd7,  3'd4, 2'd1, 1'b0, 32'h0, 32'h0, 32'h9ABCDEF0},          // R7
    {1'b0, 4'd8,  3'd5, 2'd1, 1'b0, 32'hAAAAAAAA, 32'h0, 32'h0},          // R8
    {1'b1, 4'd8,  3'd4, 2'd1, 1'b0, 32'h0, 32'h0, 32'h9ABCDEF0},          // R8 low half untouched
    {1'b0, 4'd9,  3'd7, 2'd1, 1'b0, 32'h0000BEEF, 32'h0, 32'h0},          // R9
    {1'b1, 4'd9,  3'd3, 2'd1, 1'b0, 32'h0, 32'h0, 32'h9ABCDEF0},          // R9
    {1'b1, 4'd9,  3'd4, 2'd1, 1'b0, 32'h0, 32'h0, 32'h0000BEEF},          // R9
    {1'b1, 4'd2,  3'd2, 2'd0, 1'b1, 32'h40001111, 32'h20002222, 32'h10000000}, // R2 upper
    {1'b1, 4'd2,  3'd2, 2'd0, 1'b0, 32'h11110003, 32'h2222FFFE, 32'hFFFFFFF4}, // R2 lower
    {1'b1, 4'd3,  3'd3, 2'd0, 1'b0, 32'h0, 32'h0, 32'hFFFFFFFF},          // R3 acc0 high
    {1'b1, 4'd3,  3'd4, 2'd0, 1'b0, 32'h0, 32'h0, 32'hFFFFFFF4},          // R3 acc0 low
    {1'b0, 4'd5,  3'd0, 2'd2, 1'b1, 32'h40000000, 32'h40000000, 32'h0},   // R5
    {1'b0, 4'd5,  3'd0, 2'd2, 1'b1, 32'h40000000, 32'h40000000, 32'h0},
    {1'b0, 4'd5,  3'd0, 2'd2, 1'b1, 32'h40000000, 32'h40000000, 32'h0},
    {1'b0, 4'd5,  3'd0, 2'd2, 1'b1, 32'h40000000, 32'h40000000, 32'h0},
    {1'b1, 4'd5,  3'd3, 2'd2, 1'b0, 32'h0, 32'h0, 32'h0},                 // R5 no clamp
    {1'b1, 4'd5,  3'd4, 2'd2, 1'b0, 32'h0, 32'h0, 32'h80000000},
    {1'b0, 4'd5,  3'd5, 2'd3, 1'b0, 32'h7FFFFFFF, 32'h0, 32'h0},
    {1'b0, 4'd5,  3'd6, 2'd3, 1'b0, 32'hFFFFFFFF, 32'h0, 32'h0},
    {1'b0, 4'd5,  3'd0, 2'd3, 1'b1, 32'h40000000, 32'h40000000, 32'h0},   // R5 64-bit wrap
    {1'b1, 4'd5,  3'd3, 2'd3, 1'b0, 32'h0, 32'h0, 32'h80000000},
    {1'b1, 4'd5,  3'd4, 2'd3, 1'b0, 32'h0, 32'h0, 32'h1FFFFFFF},
    {1'b0, 4'd6,  3'd1, 2'd2, 1'b1, 32'h40000000, 32'h40000000, 32'h0},   // R6 upper clamp
    {1'b1, 4'd6,  3'd3, 2'd2, 1'b0, 32'h0, 32'h0, 32'h0},
    {1'b1, 4'd6,  3'd4, 2'd2, 1'b0, 32'h0, 32'h0, 32'h7FFFFFFF}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic [1:0] s, input logic h,
                        input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op = o; acc_sel = s; hsel = h; src_a = a; src_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    check("R1 result", result, 32'h0);
    check("R1 done", {31'b0, done}, 32'h0);
    check("R1 sat_flag", {31'b0, sat_flag}, 32'h0);
    for (int i = 0; i < 4; i++) begin
      run_op(3'd3, 2'(i), 1'b0, 32'h0, 32'h0); check("R1 acc high", result, 32'h0);
      run_op(3'd4, 2'(i), 1'b0, 32'h0, 32'h0); check("R1 acc low", result, 32'h0);
    end

    for (int v = 0; v < NV; v++) begin
      run_op(VEC[v][101:99], VEC[v][98:97], VEC[v][96], VEC[v][95:64], VEC[v][63:32]);
      if (VEC[v][106]) check($sformatf("R%0d table[%0d]", VEC[v][105:102], v), result, VEC[v][31:0]);
    end
    check("R6 flag after clamp", {31'b0, sat_flag}, 32'h1);

    do_reset();
    check("R1 flag cleared", {31'b0, sat_flag}, 32'h0);
    // R10 done timing and result hold
    run_op(3'd2, 2'd0, 1'b0, 32'h0, 32'h00000002);
    check("R10 done pulse", {31'b0, done}, 32'h1);
    @(negedge clk);
    check("R10 done falls", {31'b0, done}, 32'h0);
    run_op(3'd2, 2'd0, 1'b0, 32'h00004000, 32'h00004000);
    check("R3 mul", result, 32'h20000000);
    run_op(3'd5, 2'd1, 1'b0, 32'hFFFFFFFF, 32'h0);
    check("R10 result held on write", result, 32'h20000000);
    check("R4 flag still clear", {31'b0, sat_flag}, 32'h0);
    // R4 overflow square
    run_op(3'd2, 2'd0, 1'b1, 32'h80000000, 32'h80001234);
    check("R4 product", result, 32'h7FFFFFFF);
    check("R4 flag", {31'b0, sat_flag}, 32'h1);
    // R6 lower clamp, R11 flag persists
    run_op(3'd6, 2'd1, 1'b0, 32'h80000000, 32'h0);
    run_op(3'd1, 2'd1, 1'b0, 32'h00000001, 32'h0000FFFF);
    run_op(3'd3, 2'd1, 1'b0, 32'h0, 32'h0);
    check("R6 low clamp high", result, 32'hFFFFFFFF);
    run_op(3'd4, 2'd1, 1'b0, 32'h0, 32'h0);
    check("R6 low clamp low", result, 32'h80000000);
    repeat (3) @(negedge clk);
    check("R11 sticky", {31'b0, sat_flag}, 32'h1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R10 actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule